// File: doc/BRIEF.md
# Time-Base Bit-Tap Interval Timers

This block keeps a free-running 64-bit time base and derives two periodic events from it: a fixed-interval event and a watchdog period event. Each event watches one bit of the time base, chosen by fields of a control register. The event fires when that bit goes from 0 to 1, so the period is a power of two of time-base ticks.

An event sets a sticky flag in a status register. Each interrupt output is that flag gated by an enable bit in the control register. Software writes the control register whole and clears status flags by writing ones. A resume pulse wipes the watchdog-related status bits in one cycle. The watchdog reset escalation and any decrementer are handled elsewhere.

Top module: `tapped_interval_timer`

## Requirements
- R1: After reset, ctrl_q, stat_q and timebase are all zero and both interrupt outputs are low.
- R2: timebase increases by exactly one at each clock edge where tick_en is high, and holds otherwise.
- R3: The fixed-interval tap is bit 63 - {ctrl[16:13], ctrl[25:24]} of the time base. When a tick makes that bit go from 0 to 1, stat_q[26] is set at that same edge.
- R4: A tapped bit going from 1 to 0, or staying the same, sets no status flag.
- R5: The watchdog tap is bit 63 - {ctrl[20:17], ctrl[31:30]}. When a tick makes that bit go from 0 to 1, stat_q[30] is set at that same edge.
- R6: fit_irq equals stat_q[26] AND ctrl_q[23], and wdt_irq equals stat_q[30] AND ctrl_q[27]. Both follow any change of either register with no extra delay.
- R7: A write with wr_addr=1 clears each status bit whose wr_data bit is 1 and leaves every other status bit unchanged. Status bits other than 31, 30, 29, 28 and 26 always read 0.
- R8: When an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R9: A resume pulse clears stat_q[31:28] and leaves stat_q[26] unchanged.
- R10: A write with wr_addr=0 stores all 32 bits of wr_data into ctrl_q at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the time base this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects status (write-one-to-clear) |
| wr_data | input | 32 | Write data |
| resume | input | 1 | Clear the watchdog-related status bits 31:28 |
| ctrl_q | output | 32 | Control register contents |
| stat_q | output | 32 | Status register contents |
| timebase | output | 64 | Time base count |
| fit_irq | output | 1 | Fixed-interval interrupt |
| wdt_irq | output | 1 | Watchdog interrupt |

## Verification
The time base, the status flags and the control register are each one register away from the inputs. A tick, an event, a write or a resume therefore shows up on the ports at the first clock edge after it is driven. The interrupt outputs are combinational over the two registers, so they change in that same cycle. The bench drives inputs and samples outputs on the falling edge, exactly one rising edge after each stimulus. It keeps its own model of the time base and computes the expected rising edges of each tap from the control fields it wrote.

// File: rtl/tapped_interval_timer.sv
module tapped_interval_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        resume,
  output logic [31:0] ctrl_q,
  output logic [31:0] stat_q,
  output logic [63:0] timebase,
  output logic        fit_irq,
  output logic        wdt_irq
);
  localparam logic [31:0] STAT_MASK = 32'hF400_0000;
  localparam int FIT_FLAG = 26;
  localparam int WDT_FLAG = 30;

  logic [63:0] tb_nx;
  logic [5:0]  fit_tap, wdt_tap;
  logic        fit_ev, wdt_ev;
  logic [31:0] stat_d;

  assign tb_nx   = timebase + 64'd1;
  assign fit_tap = ~{ctrl_q[16:13], ctrl_q[25:24]};
  assign wdt_tap = ~{ctrl_q[20:17], ctrl_q[31:30]};
  assign fit_ev  = tick_en & ~timebase[fit_tap] & tb_nx[fit_tap];
  assign wdt_ev  = tick_en & ~timebase[wdt_tap] & tb_nx[wdt_tap];

  assign fit_irq = stat_q[FIT_FLAG] & ctrl_q[23];
  assign wdt_irq = stat_q[WDT_FLAG] & ctrl_q[27];

  always_comb begin
    stat_d = stat_q;
    if (wr_en && wr_addr) stat_d = stat_d & ~wr_data;
    if (resume)           stat_d[31:28] = 4'b0000;
    if (fit_ev)           stat_d[FIT_FLAG] = 1'b1;
    if (wdt_ev)           stat_d[WDT_FLAG] = 1'b1;
    stat_d = stat_d & STAT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timebase <= '0;
      ctrl_q   <= '0;
      stat_q   <= '0;
    end else begin
      if (tick_en) timebase <= tb_nx;
      if (wr_en && !wr_addr) ctrl_q <= wr_data;
      stat_q <= stat_d;
    end
  end
endmodule

module tapped_interval_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic        wr_addr,
  input logic [31:0] wr_data,
  input logic        resume,
  input logic [31:0] ctrl_q,
  input logic [31:0] stat_q,
  input logic [63:0] timebase,
  input logic        fit_irq,
  input logic        wdt_irq
);
  a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> timebase == $past(timebase) + 64'd1);
  a_r2_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(timebase));
  a_r4_fit_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !$rose(stat_q[26]));
  a_r4_wdt_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !$rose(stat_q[30]));
  a_r6_fit_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fit_irq |-> ctrl_q[23] && stat_q[26]);
  a_r6_wdt_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> ctrl_q[27] && stat_q[30]);
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && !tick_en) |=> (stat_q & $past(wr_data)) == 32'd0);
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & 32'h0BFF_FFFF) == 32'd0);
  a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !tick_en) |=> stat_q[31:28] == 4'b0000);
  a_r10_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> ctrl_q == $past(wr_data));
endmodule

bind tapped_interval_timer tapped_interval_timer_chk u_chk (.*);

// File: tb/tapped_interval_timer_tb.sv
module tapped_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        resume = 1'b0;
  logic [31:0] ctrl_q, stat_q;
  logic [63:0] timebase;
  logic        fit_irq, wdt_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] tb_m = '0;

  always #10 clk = ~clk;

  tapped_interval_timer u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0; resume = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic tick();
    tick_en = 1'b1;
    step();
    tb_m = tb_m + 64'd1;
  endtask

  function automatic logic [31:0] mk_ctrl(input int wp, input int wx, input int fp, input int fx,
                                          input bit wie, input bit fie);
    logic [31:0] c = '0;
    c[31:30] = wp[1:0]; c[20:17] = wx[3:0];
    c[25:24] = fp[1:0]; c[16:13] = fx[3:0];
    c[27] = wie; c[23] = fie;
    return c;
  endfunction

  task automatic t_reset();
    check(ctrl_q == 0, "R1 ctrl", ctrl_q, 0);
    check(stat_q == 0, "R1 stat", stat_q, 0);
    check(timebase == 0, "R1 timebase", timebase, 0);
    check(!fit_irq && !wdt_irq, "R1 irqs", {fit_irq, wdt_irq}, 0);
  endtask

  task automatic t_count();
    step();
    check(timebase == tb_m, "R2 hold without tick", timebase, tb_m);
    for (int i = 0; i < 5; i++) tick();
    check(timebase == tb_m, "R2 count", timebase, tb_m);
  endtask

  task automatic t_fit_tap(input int fp, input int fx);
    int tap;
    logic rise;
    logic [63:0] old;
    logic [31:0] c;
    c = mk_ctrl(0, 0, fp, fx, 1'b0, 1'b0);
    wr(1'b0, c);
    check(ctrl_q == c, "R10 ctrl store", ctrl_q, c);
    wr(1'b1, 32'hFFFF_FFFF);
    tap = 63 - (fp | (fx << 2));
    for (int i = 0; i < 20; i++) begin
      old = tb_m;
      tick();
      rise = !old[tap] && tb_m[tap];
      check(stat_q[26] == rise, rise ? "R3 fit rise" : "R4 fit no event", stat_q[26], rise);
      check(stat_q[30] == 1'b0, "R4 wdt tap 63 quiet", stat_q[30], 0);
      if (rise) begin
        wr(1'b1, 32'h0400_0000);
        check(stat_q[26] == 1'b0, "R7 w1c fit", stat_q[26], 0);
      end
    end
  endtask

  task automatic t_wdt_and_irq();
    logic [31:0] c;
    if (tb_m[0]) tick();
    wr(1'b1, 32'hFFFF_FFFF);
    c = mk_ctrl(3, 15, 3, 15, 1'b1, 1'b1);
    wr(1'b0, c);
    tick();
    check(stat_q[30] && stat_q[26], "R5 wdt tap 0 rise", stat_q, 32'h4400_0000);
    check(wdt_irq && fit_irq, "R6 irqs on", {fit_irq, wdt_irq}, 3);
    tick();
    check(stat_q == 32'h4400_0000, "R4 fall keeps flags only", stat_q, 32'h4400_0000);
    wr(1'b0, mk_ctrl(3, 15, 3, 15, 1'b0, 1'b1));
    check(!wdt_irq && fit_irq, "R6 wdt gated by ctrl", {fit_irq, wdt_irq}, 2);
    wr(1'b1, 32'h0400_0000);
    check(stat_q == 32'h4000_0000, "R7 only bit 26 cleared", stat_q, 32'h4000_0000);
    check(!fit_irq, "R6 fit follows stat", fit_irq, 0);
    wr(1'b1, 32'h0000_0000);
    check(stat_q == 32'h4000_0000, "R7 zero write no effect", stat_q, 32'h4000_0000);
    wr(1'b0, mk_ctrl(3, 14, 0, 0, 1'b1, 1'b0));
    wr(1'b1, 32'hFFFF_FFFF);
    for (int i = 0; i < 12; i++) begin
      logic [63:0] old = tb_m;
      logic r;
      tick();
      r = !old[4] && tb_m[4];
      check(stat_q[30] == r, "R5 wdt tap 4", stat_q[30], r);
      check(wdt_irq == r, "R6 wdt irq", wdt_irq, r);
      if (r) wr(1'b1, 32'h4000_0000);
    end
  endtask

  task automatic t_collision();
    wr(1'b0, mk_ctrl(0, 0, 3, 15, 1'b0, 1'b1));
    wr(1'b1, 32'hFFFF_FFFF);
    if (tb_m[0]) tick();
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h0400_0000;
    step();
    tb_m = tb_m + 64'd1;
    check(stat_q[26] == 1'b1, "R8 event beats clear", stat_q[26], 1);
  endtask

  task automatic t_resume();
    wr(1'b0, mk_ctrl(3, 15, 3, 15, 1'b1, 1'b1));
    wr(1'b1, 32'hFFFF_FFFF);
    if (tb_m[0]) tick();
    tick();
    check(stat_q == 32'h4400_0000, "R9 setup", stat_q, 32'h4400_0000);
    resume = 1'b1;
    step();
    check(stat_q == 32'h0400_0000, "R9 resume clears 31:28", stat_q, 32'h0400_0000);
    check(!wdt_irq && fit_irq, "R9 irqs after resume", {fit_irq, wdt_irq}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_fit_tap(3, 15);
    t_fit_tap(2, 15);
    t_fit_tap(1, 15);
    t_fit_tap(3, 14);
    t_wdt_and_irq();
    t_collision();
    t_resume();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule